// File: doc/BRIEF.md
# Configuration Cycle Type Translator

This block decides what a two-bus bridge does with each configuration cycle. It looks at one address phase: the address word, the bus command, the chip-select input and which side of the bridge the cycle came from. It compares the word against the bridge's primary, secondary and subordinate bus numbers, and it returns one action code. It also returns the address and command the bridge should drive on the far bus.

On the primary side, a Type 0 cycle with chip-select asserted is claimed for the bridge's own registers. A Type 1 cycle aimed at the secondary bus is rewritten into Type 0 form, with one upper address line raised as the device select. A Type 1 cycle aimed at a bus further down is passed on unchanged. A special-cycle request for the secondary bus becomes a special-cycle command.

On the secondary side, only special-cycle requests travel upstream. Everything else is dropped. The result is registered and appears one clock after the request.

Top module: `cfgx_translator`

## Requirements
- R1: While reset is asserted and after it is released, with no request yet made, outValid, action, adOut and cmdOut are all 0.
- R2: The result for a request presented with inValid high appears on the outputs exactly one clock later, with outValid high. Whenever outValid is low, or action is IGNORE (code 0), adOut and cmdOut are 0.
- R3: The request is a configuration read (command 1010) or write (command 1011) from the primary side, with adIn[1:0]=00 and idsel high. The action is CLAIM (code 1), and adOut and cmdOut equal the request's address and command. The same request with idsel low gives IGNORE.
- R4: Bus number, device and function fields of a Type 1 address: the bus number is adIn[23:16], the device is adIn[15:11], the function is adIn[10:8] and the register is adIn[7:2].
- R5: The request is a primary-side Type 1 cycle (adIn[1:0]=01) whose bus number equals secBus, with a device number of 0 to 15, and it is not a special-cycle request. The action is TO_TYPE0 (code 2). adOut[31:16] has only bit 16+device set, adOut[15:11] and adOut[1:0] are 0, adOut[10:2] equals adIn[10:2], and cmdOut equals the command.
- R6: Under the same conditions but with a device number of 16 to 31, the action is IGNORE.
- R7: A special-cycle request is a configuration write Type 1 cycle with device 31, function 7 and register 0. From the primary side with bus number equal to secBus, it gives SPECIAL (code 4), cmdOut 0001, and adOut equal to adIn.
- R8: A primary-side Type 1 cycle whose bus number is greater than secBus and no greater than subBus gives FORWARD (code 3), with address and command unchanged.
- R9: A primary-side Type 1 cycle whose bus number is below secBus or above subBus gives IGNORE.
- R10: Any Type 0 cycle from the secondary side gives IGNORE, whatever idsel is.
- R11: A secondary-side special-cycle request whose bus number equals priBus gives SPECIAL, with cmdOut 0001 and adOut equal to adIn. This check takes priority over the range check in R12.
- R12: A secondary-side special-cycle request whose bus number lies outside secBus..subBus gives FORWARD, unchanged. Every other secondary-side Type 1 cycle gives IGNORE.
- R13: A command other than 1010 or 1011, or adIn[1:0] of 10 or 11, gives IGNORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Address phase present this cycle |
| fromSecondary | input | 1 | 1 = cycle arrived on the secondary side, 0 = primary side |
| adIn | input | 32 | Address-phase word |
| cmdIn | input | 4 | Bus command |
| idsel | input | 1 | Chip-select for the bridge's own configuration space |
| priBus | input | 8 | Primary bus number |
| secBus | input | 8 | Secondary bus number |
| subBus | input | 8 | Subordinate (highest downstream) bus number |
| outValid | output | 1 | Result valid |
| action | output | 3 | 0 IGNORE, 1 CLAIM, 2 TO_TYPE0, 3 FORWARD, 4 SPECIAL |
| adOut | output | 32 | Address to drive on the far bus |
| cmdOut | output | 4 | Command to drive on the far bus |

## Verification
The bench builds the block with its default parameters:
- a 32-bit address word,
- 8-bit bus numbers,
- sixteen select lines starting at address bit 16.

With these values every device number, on both sides of the 15/16 cutoff, can be driven directly. The bench walks bus numbers across both edges of the downstream window. One bus setup makes the secondary and subordinate numbers equal, so the forward window is empty. Another setup has bus numbers at 0 and 255.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [2:0] {
    ACT_IGNORE   = 3'd0,
    ACT_CLAIM    = 3'd1,
    ACT_TO_TYPE0 = 3'd2,
    ACT_FORWARD  = 3'd3,
    ACT_SPECIAL  = 3'd4
  } action_e;

  // Strobes handed from the decision logic to the datapath.
  typedef struct packed {
    logic load;
    logic claim;
    logic toType0;
    logic forward;
    logic special;
  } strobe_t;

  localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;
  localparam logic [3:0] CMD_SPECIAL   = 4'b0001;

  // Field positions of a Type 1 address word.
  localparam int REG_LSB = 2;
  localparam int FN_LSB  = 8;
  localparam int DEV_LSB = 11;
  localparam int BUS_LSB = 16;

endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int DEV_W       = 5,
  parameter int IDSEL_LINES = 16,
  localparam int FIELD_W    = BUS_LSB + BUS_W
) (
  input  logic               inValid,
  input  logic               fromSecondary,
  input  logic [FIELD_W-1:0] adField,
  input  logic [3:0]         cmdIn,
  input  logic               idsel,
  input  logic [BUS_W-1:0]   priBus,
  input  logic [BUS_W-1:0]   secBus,
  input  logic [BUS_W-1:0]   subBus,
  output strobe_t            strobes
);

  localparam logic [DEV_W:0] LINE_LIMIT = (DEV_W + 1)'(IDSEL_LINES);

  logic [BUS_W-1:0] busNum;
  logic [DEV_W-1:0] devNum;
  logic [2:0]       fnNum;
  logic [5:0]       regNum;
  logic isCfg, isWrite, isType0, isType1, specialPat;
  logic busIsSec, busIsPri, busBelow, busInWindow, devHasLine;

  assign busNum = adField[BUS_LSB +: BUS_W];
  assign devNum = adField[DEV_LSB +: DEV_W];
  assign fnNum  = adField[FN_LSB +: 3];
  assign regNum = adField[REG_LSB +: 6];

  assign isWrite    = (cmdIn == CMD_CFG_WRITE);
  assign isCfg      = isWrite || (cmdIn == CMD_CFG_READ);
  assign isType0    = (adField[1:0] == 2'b00);
  assign isType1    = (adField[1:0] == 2'b01);
  assign specialPat = isWrite && (devNum == '1) && (fnNum == 3'b111) && (regNum == '0);

  assign busIsSec    = (busNum == secBus);
  assign busIsPri    = (busNum == priBus);
  assign busBelow    = (busNum > secBus) && (busNum <= subBus);
  assign busInWindow = (busNum >= secBus) && (busNum <= subBus);
  assign devHasLine  = ({1'b0, devNum} < LINE_LIMIT);

  always_comb begin
    strobes      = '0;
    strobes.load = inValid;
    if (inValid && isCfg) begin
      if (!fromSecondary) begin
        if (isType0) begin
          strobes.claim = idsel;
        end else if (isType1) begin
          if (busIsSec) begin
            if (specialPat)      strobes.special = 1'b1;
            else if (devHasLine) strobes.toType0 = 1'b1;
          end else if (busBelow) begin
            strobes.forward = 1'b1;
          end
        end
      end else if (isType1 && specialPat) begin
        if (busIsPri)          strobes.special = 1'b1;
        else if (!busInWindow) strobes.forward = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgx_dp.sv
module cfgx_dp
  import cfgx_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int DEV_W       = 5,
  parameter int IDSEL_BASE  = 16,
  parameter int IDSEL_LINES = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  logic [AD_W-1:0] adIn,
  input  logic [3:0]      cmdIn,
  output logic            outValid,
  output logic [2:0]      action,
  output logic [AD_W-1:0] adOut,
  output logic [3:0]      cmdOut
);

  localparam int LOW_HI = DEV_LSB - 1;

  logic [DEV_W-1:0]       devNum;
  logic [IDSEL_LINES-1:0] selVec;
  logic [AD_W-1:0]        type0Ad;
  logic [AD_W-1:0]        nextAd;
  logic [3:0]             nextCmd;
  action_e                nextAct;

  assign devNum = adIn[DEV_LSB +: DEV_W];

  for (genvar g = 0; g < IDSEL_LINES; g++) begin : g_sel
    assign selVec[g] = (devNum == DEV_W'(g));
  end

  always_comb begin
    type0Ad = '0;
    type0Ad[IDSEL_BASE +: IDSEL_LINES] = selVec;
    type0Ad[LOW_HI:REG_LSB] = adIn[LOW_HI:REG_LSB];
  end

  always_comb begin
    nextAct = ACT_IGNORE;
    nextAd  = '0;
    nextCmd = '0;
    if (strobes.special) begin
      nextAct = ACT_SPECIAL;
      nextAd  = adIn;
      nextCmd = CMD_SPECIAL;
    end else if (strobes.claim) begin
      nextAct = ACT_CLAIM;
      nextAd  = adIn;
      nextCmd = cmdIn;
    end else if (strobes.toType0) begin
      nextAct = ACT_TO_TYPE0;
      nextAd  = type0Ad;
      nextCmd = cmdIn;
    end else if (strobes.forward) begin
      nextAct = ACT_FORWARD;
      nextAd  = adIn;
      nextCmd = cmdIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      action   <= ACT_IGNORE;
      adOut    <= '0;
      cmdOut   <= '0;
    end else begin
      outValid <= strobes.load;
      action   <= nextAct;
      adOut    <= nextAd;
      cmdOut   <= nextCmd;
    end
  end

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int BUS_W       = 8,
  parameter int DEV_W       = 5,
  parameter int IDSEL_BASE  = 16,
  parameter int IDSEL_LINES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             fromSecondary,
  input  logic [AD_W-1:0]  adIn,
  input  logic [3:0]       cmdIn,
  input  logic             idsel,
  input  logic [BUS_W-1:0] priBus,
  input  logic [BUS_W-1:0] secBus,
  input  logic [BUS_W-1:0] subBus,
  output logic             outValid,
  output logic [2:0]       action,
  output logic [AD_W-1:0]  adOut,
  output logic [3:0]       cmdOut
);

  localparam int FIELD_W = BUS_LSB + BUS_W;

  strobe_t strobes;

  cfgx_ctrl #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .IDSEL_LINES(IDSEL_LINES)
  ) u_ctrl (
    .inValid(inValid), .fromSecondary(fromSecondary),
    .adField(adIn[FIELD_W-1:0]), .cmdIn(cmdIn), .idsel(idsel),
    .priBus(priBus), .secBus(secBus), .subBus(subBus),
    .strobes(strobes)
  );

  cfgx_dp #(
    .AD_W(AD_W), .DEV_W(DEV_W), .IDSEL_BASE(IDSEL_BASE), .IDSEL_LINES(IDSEL_LINES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adIn(adIn), .cmdIn(cmdIn),
    .outValid(outValid), .action(action), .adOut(adOut), .cmdOut(cmdOut)
  );

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        fromSecondary,
  input logic [1:0]  adType,
  input logic        outValid,
  input logic [2:0]  action,
  input logic [31:0] adOut,
  input logic [3:0]  cmdOut
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && action == 3'd0 && adOut == '0 && cmdOut == '0));

  a_r2_ignore_zero: assert property (@(posedge clk) disable iff (!rstN)
    (action == 3'd0) |-> (adOut == '0 && cmdOut == '0));

  a_r5_single_line: assert property (@(posedge clk) disable iff (!rstN)
    (action == 3'd2) |-> ($countones(adOut[31:16]) == 1 && adOut[15:11] == '0 && adOut[1:0] == 2'b00));

  a_r7_special_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (action == 3'd4) |-> (cmdOut == 4'b0001));

  a_r10_sec_type0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fromSecondary && adType == 2'b00) |=> (action == 3'd0));

  a_r12_sec_no_down: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fromSecondary) |=> (action != 3'd1 && action != 3'd2));

endmodule

bind cfgx_translator cfgx_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .fromSecondary(fromSecondary),
  .adType(adIn[1:0]), .outValid(outValid), .action(action), .adOut(adOut), .cmdOut(cmdOut)
);

// File: tb/sim_cfgx_translator.sv
module sim_cfgx_translator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        fromSecondary = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cmdIn = '0;
  logic        idsel = 1'b0;
  logic [7:0]  priBus = 8'd0, secBus = 8'd2, subBus = 8'd5;
  logic        outValid;
  logic [2:0]  action;
  logic [31:0] adOut;
  logic [3:0]  cmdOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [2:0]  expAct;
  logic [31:0] expAd;
  logic [3:0]  expCmd;
  logic        expValid;
  string       expTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_translator u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fromSecondary(fromSecondary),
    .adIn(adIn), .cmdIn(cmdIn), .idsel(idsel), .priBus(priBus), .secBus(secBus),
    .subBus(subBus), .outValid(outValid), .action(action), .adOut(adOut), .cmdOut(cmdOut)
  );

  // Behavioural reference, written from the requirements.
  function automatic void model(input bit v, input bit side, input logic [31:0] ad,
                                input logic [3:0] cmd, input bit sel,
                                output logic [2:0] a, output logic [31:0] o,
                                output logic [3:0] c, output string tag);
    int bus = ad[23:16];
    int dev = ad[15:11];
    int fn  = ad[10:8];
    int rg  = ad[7:2];
    int t   = ad[1:0];
    bit cfg = (cmd == 4'hA) || (cmd == 4'hB);
    bit spec = (cmd == 4'hB) && dev == 31 && fn == 7 && rg == 0;
    a = 0; o = 0; c = 0; tag = "R13";
    if (!v) begin
      tag = "R2";
      return;
    end
    if (!cfg || t > 1) return;
    if (!side) begin
      if (t == 0) begin
        tag = "R3";
        if (sel) begin a = 1; o = ad; c = cmd; end
      end else if (bus == int'(secBus)) begin
        if (spec) begin
          tag = "R7"; a = 4; o = ad; c = 4'b0001;
        end else if (dev < 16) begin
          tag = "R5"; a = 2; c = cmd;
          o = (32'd1 << (16 + dev)) | (ad & 32'h0000_07FC);
        end else tag = "R6";
      end else if (bus > int'(secBus) && bus <= int'(subBus)) begin
        tag = "R8"; a = 3; o = ad; c = cmd;
      end else tag = "R9";
    end else begin
      if (t == 0) tag = "R10";
      else if (spec && bus == int'(priBus)) begin
        tag = "R11"; a = 4; o = ad; c = 4'b0001;
      end else if (spec && (bus < int'(secBus) || bus > int'(subBus))) begin
        tag = "R12"; a = 3; o = ad; c = cmd;
      end else tag = "R12";
    end
  endfunction

  // R4: field layout of a Type 1 word.
  function automatic logic [31:0] t1(input int bus, input int dev, input int fn, input int rg);
    return (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | (32'(rg) << 2) | 32'd1;
  endfunction

  task automatic compare(input string tag, input logic v, input logic [2:0] a,
                         input logic [31:0] o, input logic [3:0] c);
    checks++;
    if (outValid !== v || action !== a || adOut !== o || cmdOut !== c) begin
      errors++;
      $display("FAIL %s: got v=%0b act=%0d ad=%h cmd=%h, expected v=%0b act=%0d ad=%h cmd=%h",
               tag, outValid, action, adOut, cmdOut, v, a, o, c);
    end
  endtask

  // One cycle: check the result of the previous request, then present a new one.
  task automatic step(input bit v, input bit side, input logic [31:0] ad,
                      input logic [3:0] cmd, input bit sel);
    @(negedge clk);
    compare(expTag, expValid, expAct, expAd, expCmd);
    inValid = v; fromSecondary = side; adIn = ad; cmdIn = cmd; idsel = sel;
    model(v, side, ad, cmd, sel, expAct, expAd, expCmd, expTag);
    expValid = v;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", 1'b0, 3'd0, 32'd0, 4'd0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1", 1'b0, 3'd0, 32'd0, 4'd0);
    expValid = 0; expAct = 0; expAd = 0; expCmd = 0; expTag = "R2";

    // R3: primary Type 0 claim, with and without chip-select.
    step(1, 0, 32'h0000_0A10, 4'hA, 1);
    step(1, 0, 32'h0000_0A10, 4'hB, 0);
    step(0, 0, 32'h0000_0A10, 4'hB, 1);   // R2: no request
    // R4/R5: conversion at device 0, 7 and 15.
    step(1, 0, t1(2, 0, 3, 5), 4'hA, 0);
    step(1, 0, t1(2, 7, 7, 63), 4'hB, 0);
    step(1, 0, t1(2, 15, 0, 1), 4'hA, 0);
    // R6: devices 16 and 30 have no line.
    step(1, 0, t1(2, 16, 0, 0), 4'hA, 0);
    step(1, 0, t1(2, 30, 1, 2), 4'hB, 0);
    // R7: special cycle downstream; a near miss converts to nothing.
    step(1, 0, t1(2, 31, 7, 0), 4'hB, 0);
    step(1, 0, t1(2, 31, 7, 0), 4'hA, 0);
    // R8 and R9: window edges.
    step(1, 0, t1(3, 4, 0, 0), 4'hA, 0);
    step(1, 0, t1(5, 4, 0, 0), 4'hB, 0);
    step(1, 0, t1(6, 4, 0, 0), 4'hA, 0);
    step(1, 0, t1(1, 4, 0, 0), 4'hA, 0);
    step(1, 0, t1(5, 31, 7, 0), 4'hB, 0);  // R8: special-looking, forwarded
    // R10: secondary Type 0.
    step(1, 1, 32'h0000_0100, 4'hA, 1);
    // R11 and R12: secondary special requests.
    step(1, 1, t1(0, 31, 7, 0), 4'hB, 0);
    step(1, 1, t1(9, 31, 7, 0), 4'hB, 0);
    step(1, 1, t1(3, 31, 7, 0), 4'hB, 0);
    step(1, 1, t1(9, 3, 0, 0), 4'hA, 0);
    // R13: other commands and reserved type bits.
    step(1, 0, t1(2, 1, 0, 0), 4'h6, 0);
    step(1, 0, 32'h0002_0802, 4'hA, 1);
    step(1, 0, 32'h0000_0003, 4'hB, 1);

    // Empty downstream window, bus numbers at the extremes.
    priBus = 8'd255; secBus = 8'd0; subBus = 8'd0;
    step(1, 0, t1(0, 9, 2, 4), 4'hB, 0);   // R5
    step(1, 0, t1(1, 9, 2, 4), 4'hB, 0);   // R9
    step(1, 1, t1(255, 31, 7, 0), 4'hB, 0); // R11
    step(1, 1, t1(200, 31, 7, 0), 4'hB, 0); // R12

    priBus = 8'd4; secBus = 8'd8; subBus = 8'd12;
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 5);
      int bus;
      int dev = $urandom_range(0, 31);
      int fn  = $urandom_range(0, 7);
      int rg  = $urandom_range(0, 63);
      logic [31:0] ad;
      logic [3:0] cmd;
      case (pick)
        0: bus = secBus;
        1: bus = secBus + 1;
        2: bus = subBus;
        3: bus = subBus + 1;
        4: bus = priBus;
        default: bus = $urandom_range(0, 255);
      endcase
      if ($urandom_range(0, 3) == 0) begin dev = 31; fn = 7; rg = 0; end
      ad = t1(bus, dev, fn, rg);
      ad[1:0] = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      case ($urandom_range(0, 3))
        0: cmd = 4'hA;
        1, 2: cmd = 4'hB;
        default: cmd = 4'($urandom_range(0, 15));
      endcase
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, ad, cmd, $urandom_range(0, 1) == 1);
    end
    step(0, 0, 32'd0, 4'd0, 0);
    @(negedge clk);
    compare(expTag, expValid, expAct, expAd, expCmd);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule